// File: doc/BRIEF.md
# Firmware-Update Entry Waveform Sequencer

This block borrows the two lines of an I2C bus for a short while to play a fixed entry pattern that moves a target device into its direct firmware-update mode. When a start strobe arrives, the block stops passing the I2C controller's drives through and forces both lines low for a settling hold. It then drives two square waves together for a set interval: a slow one on the clock line and a fast one on the data line. The fast wave is inverted so that its rising edges fall inside the slow wave's period. A second low hold follows so the target's internal PLL can lock. After that hold the lines go back to the I2C controller and a one-cycle done pulse is raised.

All timing comes from a tick enable that fires every `CLK_PER_TICK` system clocks, which gives 1 MHz ticks by default. Both wave periods and all three phase lengths are parameters counted in those ticks. A simulation can therefore shrink the 5 ms / 50 ms / 10 ms defaults to a few ticks.

Top module: `upd_entry_seq`

## Requirements
- R1: While idle, `sclOut` equals `sclIn`, `sdaOut` equals `sdaIn` and `done` is 0. This also holds during reset.
- R2: A start strobe seen while idle begins the sequence on the next clock edge. Both outputs are then driven low for `PRE_TICKS` ticks, whatever the pass-through inputs are.
- R3: In the wave phase `sclOut` is a square wave of `SLOW_PERIOD` ticks. It is high for tick indices 0 to SLOW_PERIOD/2-1 of each period and low for the rest.
- R4: In the wave phase `sdaOut` has a period of `FAST_PERIOD` ticks. It is low for tick indices 0 to FAST_PERIOD/2-1 of each period (integer division) and high for the rest, which is the inverse of a compare-at-half pulse.
- R5: Both wave counters restart at index 0 on the first cycle of the wave phase. That cycle therefore shows `sclOut`=1 and `sdaOut`=0, and the phase relation between the two waves is the same in every run.
- R6: After `WAVE_TICKS` ticks of wave phase, both outputs are held low for `POST_TICKS` ticks.
- R7: At the end of the final hold, the outputs return to the pass-through inputs. `done` is 1 for exactly that first idle cycle.
- R8: A start strobe while the sequence is running, including in its last cycle, is ignored. The timing and outputs are unchanged, and no new sequence starts afterwards.
- R9: One tick lasts `CLK_PER_TICK` clocks. A phase of N ticks lasts exactly N*CLK_PER_TICK cycles, and the outputs change only on tick boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, one cycle |
| sclIn | input | 1 | Clock-line drive from the I2C controller |
| sdaIn | input | 1 | Data-line drive from the I2C controller |
| sclOut | output | 1 | Muxed clock-line drive |
| sdaOut | output | 1 | Muxed data-line drive |
| done | output | 1 | One-cycle pulse when the lines return to I2C |

## Verification
The sequence is run with the pass-through inputs high on both lines. This separates the forced low holds from a mux that leaks the inputs. A second run uses a mixed high/low input pair, which shows that the done cycle really switches back to the controller's values. A third run repeats the sequence while start is pulsed in the middle of the wave phase and again in the last hold cycle. A correct block keeps the exact same per-cycle trace and then stays idle, while a block that restarts or shifts its phases shows a different trace. Comparing every cycle against expected values computed from tick indices tells apart a wrong duty cycle, a wrong inversion, a phase offset between the waves, and off-by-one phase lengths.

// File: rtl/upd_entry_pkg.sv
package upd_entry_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_WAVE,
    ST_POST
  } seqStateT;

  typedef struct packed {
    logic drive;     // lines owned by the sequencer
    logic tick;      // one-cycle tick enable
    logic waveOn;    // wave phase active
    logic waveStart; // clear wave counters on this edge
  } seqCtrlT;
endpackage

// File: rtl/upd_entry_ctrl.sv
module upd_entry_ctrl
  import upd_entry_pkg::*;
#(
  parameter int CLK_PER_TICK = 50,
  parameter int PRE_TICKS    = 5000,
  parameter int WAVE_TICKS   = 50000,
  parameter int POST_TICKS   = 10000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output seqCtrlT ctrlBus,
  output logic    donePulse
);
  localparam int PS_W  = $clog2(CLK_PER_TICK + 1);
  localparam int MAX_T = (PRE_TICKS > WAVE_TICKS) ?
                         ((PRE_TICKS > POST_TICKS) ? PRE_TICKS : POST_TICKS) :
                         ((WAVE_TICKS > POST_TICKS) ? WAVE_TICKS : POST_TICKS);
  localparam int PH_W  = $clog2(MAX_T + 1);

  seqStateT        stateQ;
  logic [PS_W-1:0] preCnt;
  logic [PH_W-1:0] phCnt;
  logic [PH_W-1:0] phLen;
  logic            busy;
  logic            tickNow;
  logic            phLast;
  logic            doneQ;

  assign busy    = (stateQ != ST_IDLE);
  assign tickNow = busy && (preCnt == PS_W'(CLK_PER_TICK - 1));

  always_comb begin
    case (stateQ)
      ST_PRE:  phLen = PH_W'(PRE_TICKS);
      ST_WAVE: phLen = PH_W'(WAVE_TICKS);
      default: phLen = PH_W'(POST_TICKS);
    endcase
  end

  assign phLast = (phCnt == phLen - PH_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      preCnt <= '0;
      phCnt  <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (stateQ == ST_IDLE) begin
        preCnt <= '0;
        phCnt  <= '0;
        if (start) stateQ <= ST_PRE;
      end else begin
        preCnt <= tickNow ? '0 : preCnt + PS_W'(1);
        if (tickNow) begin
          if (phLast) begin
            phCnt <= '0;
            case (stateQ)
              ST_PRE:  stateQ <= ST_WAVE;
              ST_WAVE: stateQ <= ST_POST;
              default: begin
                stateQ <= ST_IDLE;
                doneQ  <= 1'b1;
              end
            endcase
          end else begin
            phCnt <= phCnt + PH_W'(1);
          end
        end
      end
    end
  end

  assign ctrlBus.drive     = busy;
  assign ctrlBus.tick      = tickNow;
  assign ctrlBus.waveOn    = (stateQ == ST_WAVE);
  assign ctrlBus.waveStart = tickNow && phLast && (stateQ == ST_PRE);
  assign donePulse         = doneQ;
endmodule

// File: rtl/upd_entry_wave.sv
module upd_entry_wave
  import upd_entry_pkg::*;
#(
  parameter int SLOW_PERIOD = 10,
  parameter int FAST_PERIOD = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  seqCtrlT ctrlBus,
  input  logic    sclIn,
  input  logic    sdaIn,
  output logic    sclOut,
  output logic    sdaOut
);
  localparam int SW = $clog2(SLOW_PERIOD + 1);
  localparam int FW = $clog2(FAST_PERIOD + 1);

  logic [SW-1:0] slowCnt;
  logic [FW-1:0] fastCnt;
  logic          sclWave;
  logic          sdaWave;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slowCnt <= '0;
      fastCnt <= '0;
    end else if (ctrlBus.waveStart) begin
      slowCnt <= '0;
      fastCnt <= '0;
    end else if (ctrlBus.waveOn && ctrlBus.tick) begin
      slowCnt <= (slowCnt == SW'(SLOW_PERIOD - 1)) ? '0 : slowCnt + SW'(1);
      fastCnt <= (fastCnt == FW'(FAST_PERIOD - 1)) ? '0 : fastCnt + FW'(1);
    end
  end

  assign sclWave = (slowCnt < SW'(SLOW_PERIOD / 2));
  assign sdaWave = !(fastCnt < FW'(FAST_PERIOD / 2));

  assign sclOut = ctrlBus.drive ? (ctrlBus.waveOn & sclWave) : sclIn;
  assign sdaOut = ctrlBus.drive ? (ctrlBus.waveOn & sdaWave) : sdaIn;
endmodule

// File: rtl/upd_entry_seq.sv
module upd_entry_seq
  import upd_entry_pkg::*;
#(
  parameter int CLK_PER_TICK = 50,
  parameter int SLOW_PERIOD  = 10,
  parameter int FAST_PERIOD  = 5,
  parameter int PRE_TICKS    = 5000,
  parameter int WAVE_TICKS   = 50000,
  parameter int POST_TICKS   = 10000
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclOut,
  output logic sdaOut,
  output logic done
);
  seqCtrlT ctrlBus;

  upd_entry_ctrl #(
    .CLK_PER_TICK(CLK_PER_TICK),
    .PRE_TICKS   (PRE_TICKS),
    .WAVE_TICKS  (WAVE_TICKS),
    .POST_TICKS  (POST_TICKS)
  ) ctrlInst (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .ctrlBus  (ctrlBus),
    .donePulse(done)
  );

  upd_entry_wave #(
    .SLOW_PERIOD(SLOW_PERIOD),
    .FAST_PERIOD(FAST_PERIOD)
  ) waveInst (
    .clk    (clk),
    .rstN   (rstN),
    .ctrlBus(ctrlBus),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .sclOut (sclOut),
    .sdaOut (sdaOut)
  );
endmodule

// File: rtl/upd_entry_chk.sv
module upd_entry_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic sclIn,
  input logic sdaIn,
  input logic sclOut,
  input logic sdaOut,
  input logic done,
  input logic busy,
  input logic waveOn,
  input logic tick
);
  // R1
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sclOut == sclIn) && (sdaOut == sdaIn));

  // R2
  start_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R6
  hold_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !waveOn |-> !sclOut && !sdaOut);

  // R5
  wave_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(waveOn) |-> sclOut && !sdaOut);

  // R9
  tick_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    waveOn && $past(waveOn) && !$past(tick) |-> $stable(sclOut) && $stable(sdaOut));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  done_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(busy));

  // R8
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && start |=> busy || done);
endmodule

bind upd_entry_seq upd_entry_chk chkInst (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .sclIn (sclIn),
  .sdaIn (sdaIn),
  .sclOut(sclOut),
  .sdaOut(sdaOut),
  .done  (done),
  .busy  (ctrlBus.drive),
  .waveOn(ctrlBus.waveOn),
  .tick  (ctrlBus.tick)
);

// File: tb/upd_entry_seq_test.sv
module upd_entry_seq_test;
  localparam int C    = 2;
  localparam int SLOW = 10;
  localparam int FAST = 5;
  localparam int PRE  = 6;
  localparam int WAVE = 40;
  localparam int POST = 8;
  localparam int TOT  = (PRE + WAVE + POST) * C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic sclIn = 1'b0;
  logic sdaIn = 1'b0;
  logic sclOut, sdaOut, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    int    due;
    int    sel;
    logic  exp;
    string tag;
  } itemT;

  itemT q[$];
  itemT it;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  upd_entry_seq #(
    .CLK_PER_TICK(C),
    .SLOW_PERIOD (SLOW),
    .FAST_PERIOD (FAST),
    .PRE_TICKS   (PRE),
    .WAVE_TICKS  (WAVE),
    .POST_TICKS  (POST)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclOut(sclOut), .sdaOut(sdaOut), .done(done)
  );

  task automatic chkNow(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b time=%0t", tag, what, act, exp, $time);
    end
  endtask

  // monitor: pops due items and compares with outputs
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      logic act;
      it = q.pop_front();
      act = (it.sel == 0) ? sclOut : (it.sel == 1) ? sdaOut : done;
      chkNow(it.tag, (it.sel == 0) ? "scl" : (it.sel == 1) ? "sda" : "done", act, it.exp);
    end
  end

  task automatic push(input int due, input int sel, input logic exp, input string tag);
    itemT n;
    n.due = due; n.sel = sel; n.exp = exp; n.tag = tag;
    q.push_back(n);
  endtask

  // driver: one sequence, expected per-cycle trace into the scoreboard
  task automatic runSeq(input logic pScl, input logic pSda, input bit extra);
    int base;
    @(negedge clk);
    sclIn = pScl;
    sdaIn = pSda;
    start = 1'b1;
    base = cyc + 1;
    for (int m = 0; m <= TOT + 2; m++) begin
      logic eScl, eSda, eDone;
      string tS, tD, tDn;
      eDone = 1'b0;
      tDn = "R7";
      if (m < PRE * C) begin
        eScl = 1'b0; eSda = 1'b0; tS = "R2"; tD = "R2";
        if (m == PRE * C - 1) begin tS = "R9"; tD = "R9"; end
      end else if (m < (PRE + WAVE) * C) begin
        int t;
        t = (m - PRE * C) / C;
        eScl = ((t % SLOW) < SLOW / 2);
        eSda = ((t % FAST) >= FAST / 2);
        tS = "R3"; tD = "R4";
        if (m == PRE * C) begin tS = "R5"; tD = "R5"; end
      end else if (m < TOT) begin
        eScl = 1'b0; eSda = 1'b0; tS = "R6"; tD = "R6";
      end else begin
        eScl = pScl; eSda = pSda; tS = "R7"; tD = "R7";
        eDone = (m == TOT);
      end
      if (extra && m > TOT) begin tS = "R8"; tD = "R8"; tDn = "R8"; end
      push(base + m, 0, eScl, tS);
      push(base + m, 1, eSda, tD);
      push(base + m, 2, eDone, tDn);
    end
    @(negedge clk);
    start = 1'b0;
    if (extra) begin
      repeat (PRE * C + 10) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (cyc < base + TOT - 1) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (q.size() > 0) @(negedge clk);
  endtask

  initial begin
    sclIn = 1'b1;
    sdaIn = 1'b0;
    #5;
    // R1: pass-through during reset
    chkNow("R1", "scl rst", sclOut, 1'b1);
    chkNow("R1", "sda rst", sdaOut, 1'b0);
    chkNow("R1", "done rst", done, 1'b0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    sclIn = 1'b0; sdaIn = 1'b1;
    #1;
    // R1: idle pass-through with another pattern
    chkNow("R1", "scl idle", sclOut, 1'b0);
    chkNow("R1", "sda idle", sdaOut, 1'b1);
    @(negedge clk);
    chkNow("R1", "done idle", done, 1'b0);

    runSeq(1'b1, 1'b1, 1'b0);
    runSeq(1'b1, 1'b0, 1'b0);
    runSeq(1'b0, 1'b1, 1'b1);

    repeat (4) @(negedge clk);
    // R8: still idle, no restart after the late strobe
    chkNow("R8", "scl after", sclOut, 1'b0);
    chkNow("R8", "sda after", sdaOut, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule